// File: doc/BRIEF.md
# Local Replica Way Selector

This block sits beside one slice of a distributed shared cache and makes two decisions for it. The first is placement. When a line leaves a core's primary cache through a conflict or capacity eviction, the slice may keep a local copy (a replica) of a line whose home is on another tile. Given the state of every way in the target set, the selector names the way that should take the replica. If no way may be given up, it tells the caller to send the victim on to its home tile. The second decision is lookup. On a primary-cache miss, or on a downgrade or invalidate arriving from the home tile, the slice tags are searched for a valid replica. A hit yields an invalidate for that way.

The selector prefers empty ways first, then global lines that no remote core holds, then existing replicas. It never takes a global line that remote cores still share. When several ways tie in the best class, a free-running 16-bit maximal-length LFSR picks among them. The value of the LFSR modulo the number of tied ways selects a way, counting the tied ways in index order.

Placement and lookup each use a request channel and a response channel with valid/ready handshakes. A request is accepted on an edge where its valid and ready are both high. The request ready is high whenever the response register is empty or its response is being taken in that cycle. A response stays valid, with its fields unchanged, until its ready is seen high at a clock edge. Tag comparison is done outside the block, and the block receives a per-way match vector.

Top module: `replica_way_selector`

## Requirements
- R1: Placement chooses a way with valid=0 if one exists. Otherwise it chooses a valid non-replica way with no sharers. Otherwise it chooses a valid replica way. The response class reports the category: 0 none, 1 empty way, 2 global line without sharers, 3 replica.
- R2: A way holding a valid non-replica line with the sharers flag set is never chosen.
- R3: Ties within the winning class are broken by a free-running pseudo-random source. Repeated requests with several tied ways return more than one distinct way, and the returned way always belongs to the winning class.
- R4: When every way holds a valid non-replica line with sharers, the response has class 0, way 0 and the home flag set. Otherwise the home flag is clear.
- R5: A response becomes valid on the edge that accepts its request. While response ready is low, the response stays valid with its fields held, and request ready is low.
- R6: A lookup of kind 0 (primary miss) hits when some way is valid, flagged as a replica and tag-matched. On a hit the response gives the lowest such way and sets the invalidate and move-to-primary flags. On a miss it sets only the to-home flag.
- R7: A lookup of kind 1 (probe from the home tile) searches in the same way and sets invalidate on a hit. It never sets move-to-primary or to-home.
- R8: The placement and lookup channels are independent. Requests accepted on the same edge both produce correct responses one edge later.
- R9: After reset both response valids are low and both request readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pl_valid_i | input | 1 | Placement request valid |
| pl_ready_o | output | 1 | Placement request ready |
| pl_way_valid_i | input | WAYS | Valid bit per way of the target set |
| pl_way_replica_i | input | WAYS | Replica flag per way |
| pl_way_shared_i | input | WAYS | Remote-sharers flag per way |
| pl_rsp_valid_o | output | 1 | Placement response valid |
| pl_rsp_ready_i | input | 1 | Placement response ready |
| pl_rsp_way_o | output | IDX_W | Chosen way |
| pl_rsp_class_o | output | 2 | Category of the chosen way (0 none) |
| pl_rsp_home_o | output | 1 | No replica made; victim goes home |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_ready_o | output | 1 | Lookup request ready |
| lk_kind_i | input | 1 | 0 primary miss, 1 home probe |
| lk_way_valid_i | input | WAYS | Valid bit per way |
| lk_way_replica_i | input | WAYS | Replica flag per way |
| lk_tag_match_i | input | WAYS | Tag match per way |
| lk_rsp_valid_o | output | 1 | Lookup response valid |
| lk_rsp_ready_i | input | 1 | Lookup response ready |
| lk_rsp_hit_o | output | 1 | Replica found |
| lk_rsp_way_o | output | IDX_W | Way of the replica |
| lk_rsp_inval_o | output | 1 | Invalidate that way in the slice |
| lk_rsp_to_l1_o | output | 1 | Line moves into the primary cache |
| lk_rsp_to_home_o | output | 1 | Miss forwarded to the home tile |

## Verification
A replica placement and a replica lookup can be accepted on the same edge, and so can a placement and a home probe. The bench provokes this by driving both request valids together for every random transaction, with set states drawn independently. It then checks each response against its own bench-computed expectation on the following edge. It also holds the placement response with ready low while a second placement is offered. The held response must keep its fields, and the new request must be taken only on the edge that drains the old one.

// File: rtl/rws_pkg.sv
package rws_pkg;
  typedef enum logic [1:0] {
    CLS_NONE    = 2'd0,
    CLS_EMPTY   = 2'd1,
    CLS_GFREE   = 2'd2,
    CLS_REPLICA = 2'd3
  } way_class_e;

  typedef enum logic {
    LK_MISS  = 1'b0,
    LK_PROBE = 1'b1
  } lookup_kind_e;
endpackage

// File: rtl/rws_lfsr.sv
module rws_lfsr #(
  parameter int          LFSR_W = 16,
  parameter logic [15:0] TAPS   = 16'hB400,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] rnd_o
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED[LFSR_W-1:0];
    else        state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS[LFSR_W-1:0] : '0);
  end

  assign rnd_o = state_q;

  assert_lfsr_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/rws_place_pick.sv
module rws_place_pick
  import rws_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int LFSR_W = 16,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int CNT_W = $clog2(WAYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAYS-1:0]   valid_i,
  input  logic [WAYS-1:0]   replica_i,
  input  logic [WAYS-1:0]   shared_i,
  input  logic [LFSR_W-1:0] rnd_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  way_o,
  output way_class_e        class_o
);
  logic [WAYS-1:0]  empty_m, gfree_m, repl_m, win_m;
  logic [CNT_W-1:0] cnt, pick_k, seen;
  logic [LFSR_W-1:0] mod_res;

  assign empty_m = ~valid_i;
  assign gfree_m = valid_i & ~replica_i & ~shared_i;
  assign repl_m  = valid_i & replica_i;

  always_comb begin
    if (|empty_m) begin
      win_m = empty_m; class_o = CLS_EMPTY;
    end else if (|gfree_m) begin
      win_m = gfree_m; class_o = CLS_GFREE;
    end else if (|repl_m) begin
      win_m = repl_m;  class_o = CLS_REPLICA;
    end else begin
      win_m = '0;      class_o = CLS_NONE;
    end
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < WAYS; i++) cnt = cnt + CNT_W'(win_m[i]);
  end

  assign found_o = (cnt != '0);
  assign mod_res = found_o ? (rnd_i % LFSR_W'(cnt)) : '0;
  assign pick_k  = mod_res[CNT_W-1:0];

  always_comb begin
    way_o = '0;
    seen  = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (win_m[i]) begin
        if (seen == pick_k) way_o = IDX_W'(i);
        seen = seen + 1'b1;
      end
    end
  end

  assert_best_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~valid_i)) |-> !valid_i[way_o]);
  assert_keep_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> !(valid_i[way_o] && !replica_i[way_o] && shared_i[way_o]));
  assert_decline_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !found_o |-> (&(valid_i & ~replica_i & shared_i)));
endmodule

// File: rtl/rws_replica_probe.sv
module rws_replica_probe
  import rws_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lookup_kind_e     kind_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAYS-1:0]  replica_i,
  input  logic [WAYS-1:0]  match_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] way_o,
  output logic             inval_o,
  output logic             to_l1_o,
  output logic             to_home_o
);
  logic [WAYS-1:0] hit_v;

  assign hit_v = valid_i & replica_i & match_i;
  assign hit_o = |hit_v;

  always_comb begin
    way_o = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (hit_v[i]) way_o = IDX_W'(i);
    end
  end

  assign inval_o   = hit_o;
  assign to_l1_o   = hit_o && (kind_i == LK_MISS);
  assign to_home_o = !hit_o && (kind_i == LK_MISS);

  assert_hit_real_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (valid_i[way_o] && replica_i[way_o] && match_i[way_o]));
  assert_probe_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == LK_PROBE) |-> (!to_l1_o && !to_home_o));
endmodule

// File: rtl/replica_way_selector.sv
module replica_way_selector
  import rws_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int LFSR_W = 16,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pl_valid_i,
  output logic             pl_ready_o,
  input  logic [WAYS-1:0]  pl_way_valid_i,
  input  logic [WAYS-1:0]  pl_way_replica_i,
  input  logic [WAYS-1:0]  pl_way_shared_i,
  output logic             pl_rsp_valid_o,
  input  logic             pl_rsp_ready_i,
  output logic [IDX_W-1:0] pl_rsp_way_o,
  output logic [1:0]       pl_rsp_class_o,
  output logic             pl_rsp_home_o,
  input  logic             lk_valid_i,
  output logic             lk_ready_o,
  input  logic             lk_kind_i,
  input  logic [WAYS-1:0]  lk_way_valid_i,
  input  logic [WAYS-1:0]  lk_way_replica_i,
  input  logic [WAYS-1:0]  lk_tag_match_i,
  output logic             lk_rsp_valid_o,
  input  logic             lk_rsp_ready_i,
  output logic             lk_rsp_hit_o,
  output logic [IDX_W-1:0] lk_rsp_way_o,
  output logic             lk_rsp_inval_o,
  output logic             lk_rsp_to_l1_o,
  output logic             lk_rsp_to_home_o
);
  logic [LFSR_W-1:0] rnd;
  logic              pk_found;
  logic [IDX_W-1:0]  pk_way;
  way_class_e        pk_class;
  logic              pb_hit, pb_inval, pb_to_l1, pb_to_home;
  logic [IDX_W-1:0]  pb_way;
  logic              pl_fire, lk_fire;

  rws_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd_o(rnd)
  );

  rws_place_pick #(.WAYS(WAYS), .LFSR_W(LFSR_W)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .valid_i(pl_way_valid_i), .replica_i(pl_way_replica_i), .shared_i(pl_way_shared_i),
    .rnd_i(rnd), .found_o(pk_found), .way_o(pk_way), .class_o(pk_class)
  );

  rws_replica_probe #(.WAYS(WAYS)) u_probe (
    .clk(clk), .rst_n(rst_n), .kind_i(lookup_kind_e'(lk_kind_i)),
    .valid_i(lk_way_valid_i), .replica_i(lk_way_replica_i), .match_i(lk_tag_match_i),
    .hit_o(pb_hit), .way_o(pb_way), .inval_o(pb_inval),
    .to_l1_o(pb_to_l1), .to_home_o(pb_to_home)
  );

  assign pl_ready_o = !pl_rsp_valid_o || pl_rsp_ready_i;
  assign lk_ready_o = !lk_rsp_valid_o || lk_rsp_ready_i;
  assign pl_fire    = pl_valid_i && pl_ready_o;
  assign lk_fire    = lk_valid_i && lk_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_rsp_valid_o <= 1'b0;
      pl_rsp_way_o   <= '0;
      pl_rsp_class_o <= CLS_NONE;
      pl_rsp_home_o  <= 1'b0;
    end else if (pl_fire) begin
      pl_rsp_valid_o <= 1'b1;
      pl_rsp_way_o   <= pk_way;
      pl_rsp_class_o <= pk_class;
      pl_rsp_home_o  <= !pk_found;
    end else if (pl_rsp_ready_i) begin
      pl_rsp_valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_rsp_valid_o   <= 1'b0;
      lk_rsp_hit_o     <= 1'b0;
      lk_rsp_way_o     <= '0;
      lk_rsp_inval_o   <= 1'b0;
      lk_rsp_to_l1_o   <= 1'b0;
      lk_rsp_to_home_o <= 1'b0;
    end else if (lk_fire) begin
      lk_rsp_valid_o   <= 1'b1;
      lk_rsp_hit_o     <= pb_hit;
      lk_rsp_way_o     <= pb_way;
      lk_rsp_inval_o   <= pb_inval;
      lk_rsp_to_l1_o   <= pb_to_l1;
      lk_rsp_to_home_o <= pb_to_home;
    end else if (lk_rsp_ready_i) begin
      lk_rsp_valid_o <= 1'b0;
    end
  end

  assert_pl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_rsp_valid_o && !pl_rsp_ready_i) |=>
      (pl_rsp_valid_o && $stable(pl_rsp_way_o) && $stable(pl_rsp_class_o) && $stable(pl_rsp_home_o)));
  assert_lk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_rsp_valid_o && !lk_rsp_ready_i) |=>
      (lk_rsp_valid_o && $stable(lk_rsp_way_o) && $stable(lk_rsp_hit_o)));
  assert_home_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pl_rsp_valid_o |-> (pl_rsp_home_o == (pl_rsp_class_o == CLS_NONE)));
endmodule

// File: tb/replica_way_selector_test.sv
module replica_way_selector_test;
  localparam int W  = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pl_valid_i = 0, pl_rsp_ready_i = 1;
  logic [W-1:0] pl_way_valid_i = '0, pl_way_replica_i = '0, pl_way_shared_i = '0;
  logic pl_ready_o, pl_rsp_valid_o, pl_rsp_home_o;
  logic [IW-1:0] pl_rsp_way_o;
  logic [1:0] pl_rsp_class_o;
  logic lk_valid_i = 0, lk_kind_i = 0, lk_rsp_ready_i = 1;
  logic [W-1:0] lk_way_valid_i = '0, lk_way_replica_i = '0, lk_tag_match_i = '0;
  logic lk_ready_o, lk_rsp_valid_o, lk_rsp_hit_o, lk_rsp_inval_o, lk_rsp_to_l1_o, lk_rsp_to_home_o;
  logic [IW-1:0] lk_rsp_way_o;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  replica_way_selector #(.WAYS(W)) uut (.*);

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic void best(input logic [W-1:0] v, r, s,
                               output logic [W-1:0] m, output int cls);
    if (|(~v))               begin m = ~v;          cls = 1; end
    else if (|(v & ~r & ~s)) begin m = v & ~r & ~s; cls = 2; end
    else if (|(v & r))       begin m = v & r;       cls = 3; end
    else                     begin m = '0;          cls = 0; end
  endfunction

  // Drives both channels for one edge and checks both responses (R8).
  task automatic both(input logic pv, input logic [W-1:0] v, r, s,
                      input logic lv, input logic kind, input logic [W-1:0] lvv, lr, lm);
    logic [W-1:0] m; int cls; logic [W-1:0] h; int lo;
    @(negedge clk);
    pl_valid_i = pv; pl_way_valid_i = v; pl_way_replica_i = r; pl_way_shared_i = s;
    lk_valid_i = lv; lk_kind_i = kind; lk_way_valid_i = lvv; lk_way_replica_i = lr; lk_tag_match_i = lm;
    @(posedge clk); #1;
    pl_valid_i = 0; lk_valid_i = 0;
    if (pv) begin
      best(v, r, s, m, cls);
      chk(pl_rsp_valid_o == 1, "R5 placement response valid", int'(pl_rsp_valid_o), 1);
      chk(int'(pl_rsp_class_o) == cls, "R1 class", int'(pl_rsp_class_o), cls);
      chk(pl_rsp_home_o == (cls == 0), "R4 home flag", int'(pl_rsp_home_o), int'(cls == 0));
      if (cls != 0) chk(m[pl_rsp_way_o] == 1'b1, "R3 way in winning class", int'(pl_rsp_way_o), -1);
      else          chk(pl_rsp_way_o == 0, "R4 way zero on decline", int'(pl_rsp_way_o), 0);
      if (cls != 0) chk(!(v[pl_rsp_way_o] && !r[pl_rsp_way_o] && s[pl_rsp_way_o]),
                        "R2 shared global kept", int'(pl_rsp_way_o), -1);
    end
    if (lv) begin
      h = lvv & lr & lm; lo = 0;
      for (int i = W - 1; i >= 0; i--) if (h[i]) lo = i;
      chk(lk_rsp_valid_o == 1, "R8 lookup response valid", int'(lk_rsp_valid_o), 1);
      chk(lk_rsp_hit_o == (|h), kind ? "R7 probe hit" : "R6 miss hit", int'(lk_rsp_hit_o), int'(|h));
      if (|h) chk(int'(lk_rsp_way_o) == lo, kind ? "R7 way" : "R6 way", int'(lk_rsp_way_o), lo);
      chk(lk_rsp_inval_o == (|h), kind ? "R7 inval" : "R6 inval", int'(lk_rsp_inval_o), int'(|h));
      chk(lk_rsp_to_l1_o == (!kind && (|h)), kind ? "R7 no move" : "R6 move",
          int'(lk_rsp_to_l1_o), int'(!kind && (|h)));
      chk(lk_rsp_to_home_o == (!kind && !(|h)), kind ? "R7 no home" : "R6 home",
          int'(lk_rsp_to_home_o), int'(!kind && !(|h)));
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(pl_rsp_valid_o == 0 && lk_rsp_valid_o == 0, "R9 reset valids", int'(pl_rsp_valid_o), 0);
    chk(pl_ready_o == 1 && lk_ready_o == 1, "R9 reset readies", int'(pl_ready_o), 1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // Directed R1 orderings
    both(1, 8'hFF, 8'h00, 8'hFF, 0, 0, 0, 0, 0);           // all shared global: decline R4
    both(1, 8'hF7, 8'h00, 8'hFF, 0, 0, 0, 0, 0);           // single empty way 3 R1
    chk(pl_rsp_way_o == 3, "R1 single empty way", int'(pl_rsp_way_o), 3);
    both(1, 8'hFF, 8'h01, 8'hDE, 0, 0, 0, 0, 0);           // gfree way 5 beats replica 0
    chk(pl_rsp_way_o == 5, "R1 global free beats replica", int'(pl_rsp_way_o), 5);
    both(1, 8'hFF, 8'h40, 8'hBF, 0, 0, 0, 0, 0);           // only replica way 6
    chk(pl_rsp_way_o == 6, "R2 replica chosen over shared", int'(pl_rsp_way_o), 6);

    // R3 spread of tie-break
    begin
      logic [W-1:0] seen = '0;
      for (int k = 0; k < 40; k++) begin
        both(1, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 0);
        seen[pl_rsp_way_o] = 1'b1;
      end
      chk($countones(seen) > 1, "R3 tie-break varies", $countones(seen), 2);
    end

    // Directed lookups R6/R7
    both(0, 0, 0, 0, 1, 0, 8'hFF, 8'h0C, 8'h0C);
    both(0, 0, 0, 0, 1, 0, 8'hFF, 8'h00, 8'hFF);
    both(0, 0, 0, 0, 1, 1, 8'h80, 8'h80, 8'h80);
    both(0, 0, 0, 0, 1, 1, 8'h7F, 8'h80, 8'h80);

    // R5 back-pressure
    @(negedge clk); pl_rsp_ready_i = 0;
    both(1, 8'hFE, 8'h00, 8'h00, 0, 0, 0, 0, 0);
    begin
      logic [IW-1:0] hw = pl_rsp_way_o;
      @(negedge clk);
      pl_valid_i = 1; pl_way_valid_i = 8'hFF; pl_way_replica_i = 8'h00; pl_way_shared_i = 8'hFF;
      chk(pl_ready_o == 0, "R5 ready low while held", int'(pl_ready_o), 0);
      @(posedge clk); #1;
      chk(pl_rsp_valid_o && pl_rsp_way_o == hw && pl_rsp_class_o == 1,
          "R5 held response", int'(pl_rsp_class_o), 1);
      @(negedge clk); pl_rsp_ready_i = 1;
      @(posedge clk); #1; pl_valid_i = 0;
      chk(pl_rsp_valid_o && pl_rsp_class_o == 0 && pl_rsp_home_o,
          "R5 next taken on drain", int'(pl_rsp_class_o), 0);
      @(posedge clk); #1;
      chk(pl_rsp_valid_o == 0, "R5 drained", int'(pl_rsp_valid_o), 0);
    end

    // Random concurrent traffic R8
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] v, r, s, lvv, lr, lm;
      v = 8'($urandom); if ($urandom % 3 != 0) v = 8'hFF;
      r = 8'($urandom); s = 8'($urandom) | 8'($urandom);
      lvv = 8'($urandom); lr = 8'($urandom);
      lm = ($urandom % 4 == 0) ? 8'($urandom) : 8'(1 << ($urandom % 8));
      both(1, v, r, s, 1, 1'($urandom), lvv, lr, lm);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule